// File: doc/BRIEF.md
# Selectable Square-Wave and Alarm Pin Generator

This block turns a stream of oscillator ticks into a set of related square waves and drives one shared output pin with either the chosen wave or an alarm interrupt. The input `oscTick` pulses for one clock at every half-period of a 32.768 kHz oscillator, so two ticks make one oscillator cycle. A single binary counter divides the ticks in three cascaded stages: by 4, then by 2, then by 4096. The counter bits at the stage boundaries give 32.768 kHz, 8.192 kHz, 4.096 kHz and 1 Hz, all at 50% duty. The 1 Hz stage also produces a one-cycle pulse that other logic can use as the once-per-second time-base tick.

A 2-bit rate code picks which wave reaches the pin. A new code does not take over at once. The pin keeps following the old rate until the first tick on which the newly chosen wave toggles, and from that tick it follows the new wave. The pin therefore changes level only at real toggles of a wave. When the interrupt-mode bit is set, the pin carries the active-low alarm request and ignores the wave and the enable. When neither the interrupt mode nor the wave enable is set, the pin is released, which is modelled as a constant 1.

Top module: `sqwave_pin_gen`

## Requirements
- R1: After the active-low asynchronous reset, the divider count is zero and the selected wave is low. With `sqwEn`=1 and `intMode`=0 the pin reads 0, and `secTick` reads 0 until the first tick.
- R2: Rate code 2'b11 selects 32.768 kHz. Once active, the pin changes level on every `oscTick`.
- R3: Rate code 2'b10 selects 8.192 kHz. The pin is high whenever the tick count since reset, divided by 4 with the remainder dropped, is odd.
- R4: Rate code 2'b01 selects 4.096 kHz. The pin is high whenever the tick count since reset, divided by 8 with the remainder dropped, is odd.
- R5: Rate code 2'b00 selects 1 Hz, with 32768 ticks per half-period. `secTick` is high for exactly one cycle, right after the tick that brings the count to 32768 modulo 65536, which is the rise of the 1 Hz wave.
- R6: The counter and the pin advance only on cycles with `oscTick`=1. Without ticks, the pin holds its level even when `rateSel` changes.
- R7: With `intMode`=0 and `sqwEn`=0, the pin is 1 whatever the rate and ticks. The divider keeps counting underneath.
- R8: With `intMode`=1, the pin equals the inverse of `alarmIrq`, whatever `sqwEn`, `rateSel` and the ticks.
- R9: A changed rate code takes effect on the first tick on which the newly chosen wave toggles. From that tick the pin shows that wave's new level. Before that tick the pin keeps following the previous rate.
- R10: At every rate the pin spends an equal number of ticks high and low: half the rate's period in ticks each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscTick | input | 1 | One-cycle pulse per oscillator half-period |
| rateSel | input | 2 | Rate code: 00 1 Hz, 01 4.096 kHz, 10 8.192 kHz, 11 32.768 kHz |
| sqwEn | input | 1 | Enables the square wave on the pin |
| intMode | input | 1 | 1 puts the alarm interrupt on the pin instead of the wave |
| alarmIrq | input | 1 | Active-high alarm request, shown inverted on the pin |
| pinOut | output | 1 | Open-drain pin value, where 1 means released |
| secTick | output | 1 | One-cycle pulse at each rise of the 1 Hz wave |

## Verification
The pin is driven with each of the four rate codes under an unbroken run of ticks, and its level is compared with the tick count divided by the rate's half-period. This tells the three divider tap positions apart, and a long 1 Hz run confirms both the last stage and the single `secTick` pulse. Stretches without ticks, some with the rate code changing, separate counting on ticks from counting on clocks. Rate changes are requested in mid-phase and with ticks only on alternate cycles, which shows whether the switch waits for an edge of the new wave. Runs with the enable off and with interrupt mode on, under changing rates and alarm levels, show that the pin mux gives priority to interrupt mode, then to the release.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  localparam int unsigned NUM_RATES = 4;

  // Rate codes seen on the rateSel input
  typedef enum logic [1:0] {
    RATE_SLOW  = 2'b00,  // 1 Hz
    RATE_MIDLO = 2'b01,  // 4.096 kHz
    RATE_MIDHI = 2'b10,  // 8.192 kHz
    RATE_BASE  = 2'b11   // 32.768 kHz
  } rate_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic  load;    // take a new level into the wave register this cycle
    rate_e follow;  // tap whose next level is loaded
  } strobe_t;

endpackage

// File: rtl/sqw_datapath.sv
module sqw_datapath
  import sqw_pkg::*;
#(
  parameter int unsigned DIV_A = 4,
  parameter int unsigned DIV_B = 2,
  parameter int unsigned DIV_C = 4096
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 oscTick,
  input  strobe_t              strb,
  input  logic                 sqwEn,
  input  logic                 intMode,
  input  logic                 alarmIrq,
  output logic [NUM_RATES-1:0] tapFlip,
  output logic                 pinOut,
  output logic                 secTick
);

  localparam int unsigned LOG_A = $clog2(DIV_A);
  localparam int unsigned LOG_B = $clog2(DIV_B);
  localparam int unsigned LOG_C = $clog2(DIV_C);
  // bit 0 is the undivided wave, one more bit per stage of division
  localparam int unsigned CNT_W = LOG_A + LOG_B + LOG_C + 1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [CNT_W-1:0]     cnt;
  logic [NUM_RATES-1:0] tapLvl;
  logic                 sqOut;

  // One tap per rate code: the counter bit at that stage boundary
  for (genvar i = 0; i < NUM_RATES; i++) begin : g_tap
    localparam int unsigned POS = (i == 0) ? CNT_W - 1 :
                                  (i == 1) ? LOG_A + LOG_B :
                                  (i == 2) ? LOG_A : 0;
    assign tapLvl[i] = cnt[POS];
    if (POS == 0) begin : g_lsb
      assign tapFlip[i] = oscTick;
    end else begin : g_upper
      assign tapFlip[i] = oscTick & (&cnt[POS-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      sqOut   <= 1'b0;
      secTick <= 1'b0;
    end else begin
      if (oscTick) cnt <= cnt + CNT_ONE;
      if (strb.load) sqOut <= ~tapLvl[strb.follow];
      secTick <= tapFlip[RATE_SLOW] & ~tapLvl[RATE_SLOW];
    end
  end

  // Pin mux: interrupt mode wins, then the release when the wave is off
  always_comb begin
    if (intMode)     pinOut = ~alarmIrq;
    else if (sqwEn)  pinOut = sqOut;
    else             pinOut = 1'b1;
  end

endmodule

// File: rtl/sqw_ctrl.sv
module sqw_ctrl
  import sqw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           rateSel,
  input  logic [NUM_RATES-1:0] tapFlip,
  output strobe_t              strb
);

  rate_e activeSel;
  rate_e reqSel;
  logic  switchNow;

  assign reqSel = rate_e'(rateSel);

  // Hand over only on a tick where the requested wave toggles
  always_comb begin
    switchNow   = (reqSel != activeSel) && tapFlip[reqSel];
    strb.follow = switchNow ? reqSel : activeSel;
    strb.load   = tapFlip[strb.follow];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          activeSel <= RATE_SLOW;
    else if (switchNow) activeSel <= reqSel;
  end

endmodule

// File: rtl/sqwave_pin_gen.sv
module sqwave_pin_gen
  import sqw_pkg::*;
#(
  parameter int unsigned DIV_A = 4,
  parameter int unsigned DIV_B = 2,
  parameter int unsigned DIV_C = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscTick,
  input  logic [1:0] rateSel,
  input  logic       sqwEn,
  input  logic       intMode,
  input  logic       alarmIrq,
  output logic       pinOut,
  output logic       secTick
);

  strobe_t              strb;
  logic [NUM_RATES-1:0] tapFlip;

  sqw_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rateSel (rateSel),
    .tapFlip (tapFlip),
    .strb    (strb)
  );

  sqw_datapath #(
    .DIV_A (DIV_A),
    .DIV_B (DIV_B),
    .DIV_C (DIV_C)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .oscTick  (oscTick),
    .strb     (strb),
    .sqwEn    (sqwEn),
    .intMode  (intMode),
    .alarmIrq (alarmIrq),
    .tapFlip  (tapFlip),
    .pinOut   (pinOut),
    .secTick  (secTick)
  );

endmodule

// File: rtl/sqw_check.sv
module sqw_check (
  input logic clk,
  input logic rstN,
  input logic oscTick,
  input logic sqwEn,
  input logic intMode,
  input logic alarmIrq,
  input logic pinOut,
  input logic secTick
);

  // R8: interrupt mode shows the inverted alarm request
  assert_irq_pin_R8: assert property (@(posedge clk) disable iff (!rstN)
    intMode |-> (pinOut == !alarmIrq));

  // R7: released pin when the wave is disabled outside interrupt mode
  assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!intMode && !sqwEn) |-> pinOut);

  // R6: no tick, no movement of the wave on the pin
  assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!oscTick && !intMode && sqwEn) |=> (intMode || !sqwEn || $stable(pinOut)));

  // R5: the seconds pulse lasts one cycle
  assert_sec_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> !secTick);

  // R5: the seconds pulse follows a tick
  assert_sec_after_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> $past(oscTick));

endmodule

bind sqwave_pin_gen sqw_check i_sqw_check (
  .clk      (clk),
  .rstN     (rstN),
  .oscTick  (oscTick),
  .sqwEn    (sqwEn),
  .intMode  (intMode),
  .alarmIrq (alarmIrq),
  .pinOut   (pinOut),
  .secTick  (secTick)
);

// File: tb/test_sqwave_pin_gen.sv
module test_sqwave_pin_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oscTick = 1'b0;
  logic [1:0] rateSel = 2'b11;
  logic       sqwEn = 1'b1;
  logic       intMode = 1'b0;
  logic       alarmIrq = 1'b0;
  logic       pinOut;
  logic       secTick;

  int total = 0;
  int bad = 0;
  bit running = 1'b1;

  typedef struct {
    logic  pin;
    logic  sec;
    string req;
  } exp_t;

  exp_t q[$];

  int tc = 0;       // ticks since reset
  int active = 0;   // rate the model is following

  always #2.5 clk = ~clk;

  sqwave_pin_gen i_sqwave_pin_gen (
    .clk      (clk),
    .rstN     (rstN),
    .oscTick  (oscTick),
    .rateSel  (rateSel),
    .sqwEn    (sqwEn),
    .intMode  (intMode),
    .alarmIrq (alarmIrq),
    .pinOut   (pinOut),
    .secTick  (secTick)
  );

  function automatic int halfOf(input int r);
    case (r)
      3: return 1;
      2: return 4;
      1: return 8;
      default: return 32768;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at tick %0d", req, what, act, exp, tc);
    end
  endtask

  // driver: applies one cycle of stimulus and queues what the pin must show after the edge
  task automatic step(input bit tk, input bit [1:0] rs, input bit en, input bit im,
                      input bit irq, input string req);
    exp_t e;
    bit sq;
    @(negedge clk);
    oscTick = tk; rateSel = rs; sqwEn = en; intMode = im; alarmIrq = irq;
    if (tk) begin
      tc++;
      if (int'(rs) != active && (tc % halfOf(int'(rs))) == 0) active = int'(rs);
    end
    sq = ((tc / halfOf(active)) % 2) == 1;
    e.pin = im ? !irq : (en ? sq : 1'b1);
    e.sec = tk && ((tc % 65536) == 32768);
    e.req = req;
    q.push_back(e);
  endtask

  // monitor: pops one expectation per clock, sampled just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, "pinOut", pinOut, e.pin);
        chk(e.req, "secTick", secTick, e.sec);
      end
    end
  end

  task automatic finishRun();
    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (running) begin
      bad++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1", "pinOut in reset", pinOut, 1'b0);
    chk("R1", "secTick in reset", secTick, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: no tick yet, wave low
    for (int i = 0; i < 2; i++) step(0, 2'b11, 1, 0, 0, "R1");
    // R2: fastest rate toggles every tick
    for (int i = 0; i < 16; i++) step(1, 2'b11, 1, 0, 0, "R2");
    // R6: no ticks, rate code moving
    for (int i = 0; i < 6; i++) step(0, 2'(i), 1, 0, 0, "R6");
    // R3: divide by 4 stage
    for (int i = 0; i < 24; i++) step(1, 2'b10, 1, 0, 0, "R3");
    // R4: divide by 2 after that
    for (int i = 0; i < 40; i++) step(1, 2'b01, 1, 0, 0, "R4");
    // R9: mid-phase switch to the fast rate with sparse ticks, then back
    for (int i = 0; i < 3; i++) step(1, 2'b01, 1, 0, 0, "R9");
    for (int i = 0; i < 20; i++) step(i % 2 == 0, 2'b11, 1, 0, 0, "R9");
    for (int i = 0; i < 3; i++) step(1, 2'b11, 1, 0, 0, "R9");
    for (int i = 0; i < 24; i++) step(i % 3 != 0, 2'b10, 1, 0, 0, "R9");
    // R10: balanced high and low time
    for (int i = 0; i < 48; i++) step(1, 2'b01, 1, 0, 0, "R10");
    // R7: released pin with the wave off
    for (int i = 0; i < 12; i++) step(1, 2'(i), 0, 0, 0, "R7");
    // R8: interrupt mode overrides enable and rate
    for (int i = 0; i < 16; i++) step(i % 2 == 1, 2'(i), i % 3 == 0, 1, i % 4 < 2, "R8");
    // back to the wave after interrupt mode
    for (int i = 0; i < 8; i++) step(1, 2'b01, 1, 0, 0, "R4");
    // R5: slowest rate and the seconds pulse
    for (int i = 0; i < 100000; i++) step(1, 2'b00, 1, 0, 0, "R5");

    step(0, 2'b00, 1, 0, 0, "R5");
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule